// File: doc/BRIEF.md
# Interrupt target core selector

This block decides which processor core should take a re-routable interrupt. Each core supplies three inputs: an eligibility bit, a 2-bit idle-state code and a turbo-request bit. A single mode input chooses between a power bias, which keeps sleeping cores asleep, and a performance bias, which leaves a busy core undisturbed and wakes a sleeper instead.

When a request is presented, every eligible core is ranked under the current bias. The best rank wins, and a tie goes to the lowest core index. One clock later the registered result appears: the winning core index with a valid flag, or a one-cycle no-target flag when no core was eligible.

The block only makes the choice. Core states come from outside. Waking the chosen core and delivering the vector are left to the surrounding logic. Up to eight cores are supported.

Top module: `irq_target_sel`

## Requirements
- R1: Only a core whose eligibility bit is 1 is ever reported as the target.
- R2: Core i uses eligible_i[i], turbo_req_i[i] and idle_state_i[2i+1:2i], with idle codes 0 = C0 (active), 1 = C1, 2 = C3 and 3 = C6.
- R3: With perf_mode_i = 0 (power bias), the order from best to worst is: C0 not requesting turbo, C0 requesting turbo, C1, C3, C6. An eligible C0 core therefore beats an eligible C6 core.
- R4: With perf_mode_i = 1 (performance bias), the order from best to worst is: C1, C3, C6, C0 not requesting turbo, C0 requesting turbo. An eligible C6 core therefore beats an eligible C0 core.
- R5: Among eligible cores of equal rank, the lowest index wins. The turbo bit of a core that is not in C0 has no effect on its rank.
- R6: A request on req_valid_i at one rising edge is answered at the next edge by exactly one of tgt_valid_o or no_tgt_o. Both flags are high for one cycle only, and both stay low after a cycle with no request.
- R7: When a request finds no eligible core, tgt_valid_o stays low, no_tgt_o is high for one cycle and tgt_idx_o reads 0.
- R8: tgt_idx_o keeps its value through cycles that carry no request.
- R9: While rst_n is low, tgt_valid_o, no_tgt_o and tgt_idx_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Interrupt routing request for this cycle |
| perf_mode_i | input | 1 | 0 = power bias, 1 = performance bias |
| eligible_i | input | NUM_CORES | Per-core eligibility |
| idle_state_i | input | 2*NUM_CORES | Per-core idle-state code |
| turbo_req_i | input | NUM_CORES | Per-core turbo request |
| tgt_valid_o | output | 1 | Chosen core index is valid (one-cycle pulse) |
| tgt_idx_o | output | IDX_W | Index of the chosen core |
| no_tgt_o | output | 1 | Request found no eligible core (one-cycle pulse) |

## Verification
The bench builds the block with NUM_CORES = 8, the largest supported size. At that size every index value and the full length of the comparison chain can be reached, including a winner at index 7 and a tie spread across all eight cores. Random eligibility masks, idle codes and turbo bits in both biases are checked against a ranking model in the bench. Directed cases cover the C0 versus C6 reversal, the turbo fallback, equal-rank ties and the empty mask.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int RANK_W = 3;
  typedef logic [RANK_W-1:0] rank_t;

  typedef enum logic [1:0] {
    IDLE_C0 = 2'd0,
    IDLE_C1 = 2'd1,
    IDLE_C3 = 2'd2,
    IDLE_C6 = 2'd3
  } idle_e;

  // Lower rank is a better target.
  function automatic rank_t rank_of(input idle_e st, input logic turbo, input logic perf);
    rank_t r;
    if (!perf) begin
      case (st)
        IDLE_C0: r = turbo ? rank_t'(1) : rank_t'(0);
        IDLE_C1: r = rank_t'(2);
        IDLE_C3: r = rank_t'(3);
        default: r = rank_t'(4);
      endcase
    end else begin
      case (st)
        IDLE_C1: r = rank_t'(0);
        IDLE_C3: r = rank_t'(1);
        IDLE_C6: r = rank_t'(2);
        default: r = turbo ? rank_t'(4) : rank_t'(3);
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_core_rank.sv
module irq_core_rank
  import irq_sel_pkg::*;
(
  input  logic        elig_i,
  input  logic [1:0]  idle_i,
  input  logic        turbo_i,
  input  logic        perf_i,
  output rank_t       key_o,
  output logic        vld_o
);

  always_comb begin
    vld_o = elig_i;
    key_o = rank_of(idle_e'(idle_i), turbo_i, perf_i);
  end

endmodule

// File: rtl/irq_pick_min.sv
module irq_pick_min
  import irq_sel_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  rank_t            cand_key_i [N],
  input  logic [N-1:0]     cand_vld_i,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o,
  output rank_t            win_key_o
);

  rank_t            best_key [N+1];
  logic [IDX_W-1:0] best_idx [N+1];
  logic             best_vld [N+1];

  assign best_key[0] = '1;
  assign best_idx[0] = '0;
  assign best_vld[0] = 1'b0;

  // Strict comparison in index order keeps the lowest index on ties.
  for (genvar i = 0; i < N; i++) begin : g_stage
    logic take;
    assign take = cand_vld_i[i] && (!best_vld[i] || (cand_key_i[i] < best_key[i]));
    assign best_key[i+1] = take ? cand_key_i[i] : best_key[i];
    assign best_idx[i+1] = take ? IDX_W'(i)     : best_idx[i];
    assign best_vld[i+1] = best_vld[i] | cand_vld_i[i];
  end

  assign win_vld_o = best_vld[N];
  assign win_idx_o = best_idx[N];
  assign win_key_o = best_key[N];

  always_comb begin
    if (win_vld_o) begin
      a_r1_winner_eligible: assert (cand_vld_i[win_idx_o]);
      for (int i = 0; i < N; i++) begin
        if (cand_vld_i[i]) begin
          a_r5_winner_best: assert ((cand_key_i[i] > win_key_o) ||
                                    ((cand_key_i[i] == win_key_o) && (IDX_W'(i) >= win_idx_o)));
        end
      end
    end
  end

endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel
  import irq_sel_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid_i,
  input  logic                   perf_mode_i,
  input  logic [NUM_CORES-1:0]   eligible_i,
  input  logic [2*NUM_CORES-1:0] idle_state_i,
  input  logic [NUM_CORES-1:0]   turbo_req_i,
  output logic                   tgt_valid_o,
  output logic [IDX_W-1:0]       tgt_idx_o,
  output logic                   no_tgt_o
);

  rank_t            key [NUM_CORES];
  logic [NUM_CORES-1:0] vld;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  rank_t            win_key;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    irq_core_rank u_rank (
      .elig_i  (eligible_i[c]),
      .idle_i  (idle_state_i[2*c +: 2]),
      .turbo_i (turbo_req_i[c]),
      .perf_i  (perf_mode_i),
      .key_o   (key[c]),
      .vld_o   (vld[c])
    );
  end

  irq_pick_min #(.N(NUM_CORES), .IDX_W(IDX_W)) u_pick (
    .cand_key_i (key),
    .cand_vld_i (vld),
    .win_vld_o  (win_vld),
    .win_idx_o  (win_idx),
    .win_key_o  (win_key)
  );

  logic             valid_d, none_d;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    valid_d = req_valid_i &  win_vld;
    none_d  = req_valid_i & ~win_vld;
    idx_en  = req_valid_i;
    idx_d   = win_vld ? win_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_valid_o <= 1'b0;
      no_tgt_o    <= 1'b0;
      tgt_idx_o   <= '0;
    end else begin
      tgt_valid_o <= valid_d;
      no_tgt_o    <= none_d;
      if (idx_en) tgt_idx_o <= idx_d;
    end
  end

  a_r6_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> (tgt_valid_o != no_tgt_o));

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!tgt_valid_o && !no_tgt_o));

  a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (eligible_i == '0)) |=> (no_tgt_o && (tgt_idx_o == '0)));

  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> $stable(tgt_idx_o));

endmodule

// File: tb/irq_target_sel_tb.sv
module irq_target_sel_tb;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req;
  logic         mode;
  logic [N-1:0] elig;
  logic [2*N-1:0] idle;
  logic [N-1:0] turbo;
  logic         t_vld;
  logic [2:0]   t_idx;
  logic         t_none;

  int checks = 0;
  int errs   = 0;
  logic [2:0] held_idx = 3'd0;

  always #5 clk = ~clk;

  irq_target_sel #(.NUM_CORES(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req),
    .perf_mode_i  (mode),
    .eligible_i   (elig),
    .idle_state_i (idle),
    .turbo_req_i  (turbo),
    .tgt_valid_o  (t_vld),
    .tgt_idx_o    (t_idx),
    .no_tgt_o     (t_none)
  );

  // Score from the requirement orderings; smaller is preferred.
  function automatic int score(input logic [1:0] st, input logic tb, input logic pm);
    if (!pm) return (st == 2'd0) ? int'(tb) : 2 * int'(st) + 1;
    else     return (st == 2'd0) ? 10 + int'(tb) : int'(st);
  endfunction

  function automatic logic [3:0] model(input logic pm, input logic [N-1:0] el,
                                       input logic [2*N-1:0] id, input logic [N-1:0] tb);
    int best = 1000;
    logic [3:0] r = 4'd0;
    for (int i = 0; i < N; i++) begin
      if (el[i] && score(id[2*i +: 2], tb[i], pm) < best) begin
        best = score(id[2*i +: 2], tb[i], pm);
        r = {1'b1, 3'(i)};
      end
    end
    return r;
  endfunction

  task automatic step(input logic rq, input logic pm, input logic [N-1:0] el,
                      input logic [2*N-1:0] id, input logic [N-1:0] tb, input string tag);
    logic [3:0] m;
    logic ev, en;
    logic [2:0] ei;
    req = rq; mode = pm; elig = el; idle = id; turbo = tb;
    @(posedge clk);
    m = model(pm, el, id, tb);
    if (rq) begin
      ev = m[3]; en = !m[3]; ei = m[3] ? m[2:0] : 3'd0;
      held_idx = ei;
    end else begin
      ev = 1'b0; en = 1'b0; ei = held_idx;
    end
    @(negedge clk);
    checks++;
    if (t_vld !== ev || t_none !== en || t_idx !== ei) begin
      errs++;
      $display("FAIL %s: actual vld=%0b none=%0b idx=%0d expected vld=%0b none=%0b idx=%0d",
               tag, t_vld, t_none, t_idx, ev, en, ei);
    end
  endtask

  // idle code for one core at position p
  function automatic logic [2*N-1:0] st_at(input int p, input logic [1:0] st);
    return (2*N)'(st) << (2*p);
  endfunction

  initial begin
    #2000000;
    errs++;
    $display("FAIL R6 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [2*N-1:0] all_c6;
    logic [2*N-1:0] all_c1;
    all_c6 = '1;
    all_c1 = {N{2'b01}};
    rst_n = 1'b0; req = 1'b1; mode = 1'b0; elig = '1; idle = '0; turbo = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (t_vld !== 1'b0 || t_none !== 1'b0 || t_idx !== 3'd0) begin
      errs++;
      $display("FAIL R9: actual vld=%0b none=%0b idx=%0d expected 0 0 0", t_vld, t_none, t_idx);
    end
    rst_n = 1'b1;
    req = 1'b0;
    @(negedge clk);

    // R3: power bias, core2 in C0 and core5 in C6 -> core2
    step(1, 0, 8'b0010_0100, all_c6 & ~st_at(2, 2'b11), '0, "R3");
    // R4: performance bias, same case -> core5
    step(1, 1, 8'b0010_0100, all_c6 & ~st_at(2, 2'b11), '0, "R4");
    // R3: power bias, C0 turbo core1 vs C0 non-turbo core4 -> core4
    step(1, 0, 8'b0001_0010, '0, 8'b0000_0010, "R3");
    // R4: fallback to non-turbo active core -> core4
    step(1, 1, 8'b0001_0010, '0, 8'b0000_0010, "R4");
    // R5: both active with turbo -> lowest index core1
    step(1, 1, 8'b0001_0010, '0, 8'b0001_0010, "R5");
    // R4: shallowest sleep among C6@0, C1@3, C3@6 -> core3
    step(1, 1, 8'b0100_1001, st_at(0, 2'd3) | st_at(3, 2'd1) | st_at(6, 2'd2), '0, "R4");
    // R2: power bias, C3@1 vs C1@6 -> core6
    step(1, 0, 8'b0100_0010, st_at(1, 2'd2) | st_at(6, 2'd1), '0, "R2");
    // R5: all cores in C1 -> core0
    step(1, 0, '1, all_c1, '0, "R5");
    // R5: ties over mask, lowest eligible -> core5
    step(1, 0, 8'b1010_0000, all_c1, '0, "R5");
    // R5: turbo ignored on sleeping cores, both C3 -> core2
    step(1, 1, 8'b0010_0100, st_at(2, 2'd2) | st_at(5, 2'd2), 8'b0000_0100, "R5");
    // R1: ineligible active core0, only core7 eligible -> core7
    step(1, 0, 8'b1000_0000, all_c6 & ~st_at(0, 2'b11), '0, "R1");
    // R6/R8: no request, outputs quiet and index held at 7
    step(0, 0, '1, '0, '0, "R6");
    step(0, 1, 8'b0000_0001, '0, '0, "R8");
    // R7: empty mask
    step(1, 0, '0, '0, '0, "R7");
    step(0, 0, '0, '0, '0, "R6");
    // back-to-back requests
    step(1, 1, 8'b0000_0011, st_at(1, 2'd3), '0, "R4");
    step(1, 0, 8'b0000_0011, st_at(1, 2'd3), '0, "R3");

    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] el;
      logic rq;
      el = N'($urandom);
      if ($urandom_range(0, 9) == 0) el = '0;
      rq = ($urandom_range(0, 3) != 0);
      step(rq, 1'($urandom), el, (2*N)'($urandom), N'($urandom),
           rq ? (el == '0 ? "R7" : "R1") : "R8");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule